// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache

This block sits between a 32-bit processor port and a word-wide backing memory. It keeps 16 lines of 32 words (128 bytes each, 2 KB in all) in a direct-mapped arrangement. Each line has a tag, a valid bit and a dirty bit. A lookup that hits completes in the same cycle. A lookup that misses stalls the processor while the cache first writes the old line back to memory if it is dirty, then refills the line one word at a time. After the refill, the held request is replayed as a hit.

Stores that hit change only the cache copy and set the dirty bit. A store that misses first brings the line in, then merges the word. Three free-running counters report completed accesses, misses and dirty write-backs. When only the read strobe is used, the same block serves as an instruction cache and its write-back count stays at zero.

The processor must hold its address, strobes and write data steady until it sees ready. The memory side holds a read or write strobe together with a word address until the memory answers with a one-cycle acknowledge. Read data is taken in the acknowledge cycle.

Top module: `dm_wb_cache`

## Requirements
- R1: After reset every line is invalid and clean, all three counters read zero, cpu_ready is low and neither memory strobe is asserted.
- R2: A processor byte address is split as word-in-line = bits [6:2], set = bits [10:7] and tag = bits [31:11]. Memory word addresses are formed from a tag, a set and a word number in the same positions, with bits [1:0] zero.
- R3: A read whose set holds a valid line with a matching tag raises cpu_ready in the cycle the request is presented, returns the cached word on cpu_rdata and starts no memory transfer.
- R4: A write that hits updates only the cached word, starts no memory transfer and marks the line dirty. A later read of that address returns the new value.
- R5: A miss on a clean or invalid line issues exactly 32 memory reads, at words 0 to 31 of the requested line in ascending order, then completes the access. cpu_ready stays low for the whole miss.
- R6: A miss on a valid dirty line first issues 32 memory writes of the old line's words, at the old tag's addresses, words 0 to 31 in order. It then issues the 32 refill reads. Memory afterwards holds the stored values.
- R7: A write miss allocates the line: the refill completes, then the written word is merged and the line is dirty. The other words of the line hold memory's contents.
- R8: cnt_access increases by one for every completed processor access, whether it hit or missed.
- R9: cnt_miss increases by one for each miss, in the cycle after the miss is detected.
- R10: cnt_wb increases by one for each dirty line evicted. A run that uses only reads leaves it at zero.
- R11: mem_rd and mem_wr are never both high. While either is high and mem_ack is low, the strobe and mem_addr hold steady. One word moves per mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 32 | Processor byte address |
| cpu_rd | input | 1 | Processor read request |
| cpu_wr | input | 1 | Processor write request |
| cpu_wdata | input | 32 | Processor store data |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready |
| cpu_ready | output | 1 | Access completes this cycle |
| mem_addr | output | 32 | Backing memory word address (byte form) |
| mem_rd | output | 1 | Backing memory read strobe |
| mem_wr | output | 1 | Backing memory write strobe |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Refill data, taken with mem_ack |
| mem_ack | input | 1 | One word transferred |
| cnt_access | output | 32 | Completed access count |
| cnt_miss | output | 32 | Miss count |
| cnt_wb | output | 32 | Dirty eviction count |

## Verification
The bench targets a conflict on a set whose line is dirty. It checks that all 32 write-backs reach the old tag's addresses before any refill read. A design that refilled first, or used the new tag for the victim, would lose stored data, and the check of backing memory catches this.

A write miss is followed by reads of both the written word and a neighbouring word. This exposes a design that skips allocation or lets the refill overwrite the merged word.

The old line is then fetched again after its eviction. A dirty bit left set, or a write-back that never happened, shows up as stray memory writes or stale data.

Hit latency of zero stall cycles and the exact order of refill addresses are checked on every miss. Counter values are compared after each scenario, which catches counting per beat instead of per event.

// File: rtl/cache_pkg.sv
package cache_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int BYTE_LO = 2;

  typedef enum logic [1:0] {
    CS_LOOKUP = 2'd0,
    CS_EVICT  = 2'd1,
    CS_REFILL = 2'd2
  } cache_state_e;

  // slice an address field given its low bit and width
  function automatic logic [ADDR_W-1:0] addr_field(input logic [ADDR_W-1:0] a,
                                                   input int lo, input int w);
    logic [63:0] wide;
    wide = 64'(a) >> lo;
    wide = wide & ((64'd1 << w) - 64'd1);
    return wide[ADDR_W-1:0];
  endfunction
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int SETS  = 16,
  parameter int TAG_W = 21,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] line_tag,
  output logic             line_valid,
  output logic             line_dirty,
  input  logic             fill_done,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             set_dirty
);
  logic [SETS-1:0]  valid_q;
  logic [SETS-1:0]  dirty_q;
  logic [TAG_W-1:0] tag_q [SETS];

  assign line_tag   = tag_q[idx];
  assign line_valid = valid_q[idx];
  assign line_dirty = dirty_q[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_done) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= 1'b0;
    end else if (set_dirty) begin
      dirty_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_done) tag_q[idx] <= fill_tag;
  end
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
  parameter int SETS       = 16,
  parameter int LINE_WORDS = 32,
  parameter int DATA_W     = 32,
  localparam int IDX_W = $clog2(SETS),
  localparam int OFS_W = $clog2(LINE_WORDS),
  localparam int DEPTH = SETS * LINE_WORDS
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [OFS_W-1:0]  wr_word,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  a_idx,
  input  logic [OFS_W-1:0]  a_word,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  input  logic [OFS_W-1:0]  b_word,
  output logic [DATA_W-1:0] b_data
);
  logic [DATA_W-1:0] words [DEPTH];

  function automatic logic [IDX_W+OFS_W-1:0] flat(input logic [IDX_W-1:0] i,
                                                  input logic [OFS_W-1:0] w);
    return {i, w};
  endfunction

  assign a_data = words[flat(a_idx, a_word)];
  assign b_data = words[flat(b_idx, b_word)];

  always_ff @(posedge clk) begin
    if (wr_en) words[flat(wr_idx, wr_word)] <= wr_data;
  end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
#(
  parameter int LINE_WORDS = 32,
  localparam int OFS_W = $clog2(LINE_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             hit,
  input  logic             victim_dirty,
  input  logic             mem_ack,
  output cache_state_e     state,
  output logic [OFS_W-1:0] beat,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             ev_miss,
  output logic             ev_fill_beat,
  output logic             ev_fill_done,
  output logic             ready
);
  function automatic logic last_beat(input logic [OFS_W-1:0] b);
    return b == OFS_W'(LINE_WORDS - 1);
  endfunction

  logic in_lookup;
  assign in_lookup    = (state == CS_LOOKUP);
  assign ready        = in_lookup && req && hit;
  assign ev_miss      = in_lookup && req && !hit;
  assign mem_wr       = (state == CS_EVICT);
  assign mem_rd       = (state == CS_REFILL);
  assign ev_fill_beat = mem_rd && mem_ack;
  assign ev_fill_done = ev_fill_beat && last_beat(beat);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= CS_LOOKUP;
      beat  <= '0;
    end else begin
      unique case (state)
        CS_LOOKUP: if (ev_miss) begin
          state <= victim_dirty ? CS_EVICT : CS_REFILL;
          beat  <= '0;
        end
        CS_EVICT: if (mem_ack) begin
          if (last_beat(beat)) begin
            state <= CS_REFILL;
            beat  <= '0;
          end else begin
            beat <= beat + 1'b1;
          end
        end
        CS_REFILL: if (mem_ack) begin
          if (last_beat(beat)) begin
            state <= CS_LOOKUP;
            beat  <= '0;
          end else begin
            beat <= beat + 1'b1;
          end
        end
        default: state <= CS_LOOKUP;
      endcase
    end
  end
endmodule

// File: rtl/cache_stats.sv
module cache_stats #(
  parameter int N_EV  = 3,
  parameter int CNT_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_EV-1:0]            inc,
  output logic [N_EV-1:0][CNT_W-1:0] count
);
  for (genvar g = 0; g < N_EV; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)      count[g] <= '0;
      else if (inc[g]) count[g] <= count[g] + 1'b1;
    end
  end
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache
  import cache_pkg::*;
#(
  parameter int SETS       = 16,
  parameter int LINE_WORDS = 32,
  parameter int CNT_W      = 32,
  localparam int OFS_W  = $clog2(LINE_WORDS),
  localparam int IDX_W  = $clog2(SETS),
  localparam int IDX_LO = BYTE_LO + OFS_W,
  localparam int TAG_LO = IDX_LO + IDX_W,
  localparam int TAG_W  = ADDR_W - TAG_LO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic [CNT_W-1:0]  cnt_access,
  output logic [CNT_W-1:0]  cnt_miss,
  output logic [CNT_W-1:0]  cnt_wb
);
  localparam int N_EV = 3;

  logic [OFS_W-1:0] req_word;
  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] req_tag;
  assign req_word = OFS_W'(addr_field(cpu_addr, BYTE_LO, OFS_W));
  assign req_idx  = IDX_W'(addr_field(cpu_addr, IDX_LO, IDX_W));
  assign req_tag  = TAG_W'(addr_field(cpu_addr, TAG_LO, TAG_W));

  function automatic logic [ADDR_W-1:0] word_addr(input logic [TAG_W-1:0] t,
                                                  input logic [IDX_W-1:0] i,
                                                  input logic [OFS_W-1:0] w);
    return {t, i, w, {BYTE_LO{1'b0}}};
  endfunction

  // named internal events
  logic             req, hit, victim_dirty;
  logic             ev_miss, ev_fill_beat, ev_fill_done, ev_wb_start, ev_store_hit;
  logic [TAG_W-1:0] line_tag;
  logic             line_valid, line_dirty;
  cache_state_e     state;
  logic [OFS_W-1:0] beat;

  assign req          = cpu_rd || cpu_wr;
  assign hit          = line_valid && (line_tag == req_tag);
  assign victim_dirty = line_valid && line_dirty;
  assign ev_wb_start  = ev_miss && victim_dirty;
  assign ev_store_hit = cpu_ready && cpu_wr;

  cache_ctrl #(.LINE_WORDS(LINE_WORDS)) u_ctrl (
    .clk, .rst_n, .req, .hit, .victim_dirty, .mem_ack,
    .state, .beat, .mem_rd, .mem_wr,
    .ev_miss, .ev_fill_beat, .ev_fill_done, .ready(cpu_ready)
  );

  cache_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk, .rst_n, .idx(req_idx),
    .line_tag, .line_valid, .line_dirty,
    .fill_done(ev_fill_done), .fill_tag(req_tag), .set_dirty(ev_store_hit)
  );

  logic              dwr_en;
  logic [OFS_W-1:0]  dwr_word;
  logic [DATA_W-1:0] dwr_data;
  assign dwr_en   = ev_fill_beat || ev_store_hit;
  assign dwr_word = ev_fill_beat ? beat : req_word;
  assign dwr_data = ev_fill_beat ? mem_rdata : cpu_wdata;

  cache_data_store #(.SETS(SETS), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)) u_data (
    .clk, .wr_en(dwr_en), .wr_idx(req_idx), .wr_word(dwr_word), .wr_data(dwr_data),
    .a_idx(req_idx), .a_word(req_word), .a_data(cpu_rdata),
    .b_idx(req_idx), .b_word(beat),     .b_data(mem_wdata)
  );

  assign mem_addr = (state == CS_EVICT) ? word_addr(line_tag, req_idx, beat)
                                        : word_addr(req_tag, req_idx, beat);

  logic [N_EV-1:0]            stat_inc;
  logic [N_EV-1:0][CNT_W-1:0] stat_cnt;
  assign stat_inc = {ev_wb_start, ev_miss, cpu_ready};

  cache_stats #(.N_EV(N_EV), .CNT_W(CNT_W)) u_stats (
    .clk, .rst_n, .inc(stat_inc), .count(stat_cnt)
  );

  assign cnt_access = stat_cnt[0];
  assign cnt_miss   = stat_cnt[1];
  assign cnt_wb     = stat_cnt[2];
endmodule

// File: rtl/dm_wb_cache_chk.sv
module dm_wb_cache_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_rd,
  input logic             cpu_wr,
  input logic             cpu_ready,
  input logic             mem_rd,
  input logic             mem_wr,
  input logic             mem_ack,
  input logic [31:0]      mem_addr,
  input logic             ev_miss,
  input logic             victim_dirty,
  input logic [CNT_W-1:0] cnt_miss,
  input logic [CNT_W-1:0] cnt_wb
);
  assert_ready_has_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> (cpu_rd || cpu_wr));

  assert_stall_during_mem_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> !cpu_ready);

  assert_clean_miss_reads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_miss && !victim_dirty) |=> (mem_rd && !mem_wr));

  assert_dirty_miss_writes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_miss && victim_dirty) |=> (mem_wr && !mem_rd));

  assert_evict_before_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wr) |-> mem_rd);

  assert_strobes_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_hold_until_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && !mem_ack) |=>
      ($stable(mem_addr) && $stable(mem_rd) && $stable(mem_wr)));

  assert_miss_counted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> (cnt_miss == $past(cnt_miss) + 1'b1));

  assert_wb_counted_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_miss && victim_dirty) |=> (cnt_wb == $past(cnt_wb) + 1'b1));
endmodule

bind dm_wb_cache dm_wb_cache_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_ready(cpu_ready),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .ev_miss(ev_miss), .victim_dirty(victim_dirty), .cnt_miss(cnt_miss), .cnt_wb(cnt_wb)
);

// File: tb/test_dm_wb_cache.sv
module test_dm_wb_cache;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 4096;
  localparam int LOG_SZ     = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0, cpu_rdata;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0, cpu_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr, mem_ack;
  logic [31:0] cnt_access, cnt_miss, cnt_wb;

  always #(CLK_PERIOD/2) clk = ~clk;

  dm_wb_cache i_dm_wb_cache (
    .clk, .rst_n, .cpu_addr, .cpu_rd, .cpu_wr, .cpu_wdata, .cpu_rdata, .cpu_ready,
    .mem_addr, .mem_rd, .mem_wr, .mem_wdata, .mem_rdata, .mem_ack,
    .cnt_access, .cnt_miss, .cnt_wb
  );

  function automatic logic [31:0] pattern(input int i);
    return 32'(i) * 32'h0001_9E37 + 32'h1234_5000;
  endfunction

  // backing memory model and transfer log
  logic [31:0] bmem [MEM_WORDS];
  logic        log_wr [LOG_SZ];
  logic [31:0] log_addr [LOG_SZ];
  int          log_n;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      log_n     <= 0;
      for (int i = 0; i < MEM_WORDS; i++) bmem[i] <= pattern(i);
    end else begin
      mem_ack <= (mem_rd || mem_wr) && !mem_ack;
      if (mem_rd && !mem_ack) mem_rdata <= bmem[mem_addr[13:2]];
      if (mem_wr && mem_ack) bmem[mem_addr[13:2]] <= mem_wdata;
      if (mem_ack && log_n < LOG_SZ) begin
        log_wr[log_n]   <= mem_wr;
        log_addr[log_n] <= mem_addr;
        log_n           <= log_n + 1;
      end
    end
  end

  int total = 0, bad = 0;
  logic [31:0] shadow [MEM_WORDS];
  int exp_acc = 0, exp_miss = 0, exp_wb = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // one processor access; cyc counts stall cycles, base marks log start
  task automatic do_acc(input bit wr, input logic [31:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int cyc, output int base);
    base = log_n;
    cpu_addr = a; cpu_wr = wr; cpu_rd = !wr; cpu_wdata = wd; cyc = 0;
    #1;
    while (!cpu_ready) begin
      @(negedge clk);
      cyc++;
    end
    rd = cpu_rdata;
    exp_acc++;
    if (wr) shadow[a[13:2]] = wd;
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
  endtask

  // check a run of LINE transfers in the log: kind and ascending addresses
  task automatic chk_burst(input int start, input bit is_wr, input logic [31:0] line,
                           input string rq);
    bit ok = 1'b1;
    logic [31:0] bad_a = '0, bad_e = '0;
    for (int k = 0; k < 32; k++) begin
      if (log_wr[start+k] != is_wr || log_addr[start+k] != line + 32'(4*k)) begin
        if (ok) begin bad_a = log_addr[start+k]; bad_e = line + 32'(4*k); end
        ok = 1'b0;
      end
    end
    chk(ok, rq, is_wr ? "write-back order" : "refill order", bad_a, bad_e);
  endtask

  task automatic chk_counters(input string tag);
    chk(cnt_access == 32'(exp_acc), "R8", {tag, " access count"}, cnt_access, 32'(exp_acc));
    chk(cnt_miss == 32'(exp_miss), "R9", {tag, " miss count"}, cnt_miss, 32'(exp_miss));
    chk(cnt_wb == 32'(exp_wb), "R10", {tag, " write-back count"}, cnt_wb, 32'(exp_wb));
  endtask

  task automatic t_reset();
    chk(cnt_access == 0 && cnt_miss == 0 && cnt_wb == 0, "R1", "counters", cnt_access | cnt_miss | cnt_wb, 0);
    chk(!cpu_ready && !mem_rd && !mem_wr, "R1", "idle outputs", {29'b0, cpu_ready, mem_rd, mem_wr}, 0);
  endtask

  // set 1, tag 0, word 1 (R2 field split)
  task automatic t_read_miss_clean();
    logic [31:0] d; int cyc, b;
    do_acc(1'b0, 32'h0000_0084, '0, d, cyc, b);
    exp_miss++;
    chk(d == shadow[33], "R5", "miss data", d, shadow[33]);
    chk(log_n - b == 32, "R5", "refill beats", 32'(log_n - b), 32);
    chk_burst(b, 1'b0, 32'h0000_0080, "R5");
    chk(cyc >= 64, "R5", "stall length", 32'(cyc), 64);
  endtask

  task automatic t_read_hit();
    logic [31:0] d; int cyc, b;
    do_acc(1'b0, 32'h0000_00F8, '0, d, cyc, b);
    chk(cyc == 0, "R3", "hit latency", 32'(cyc), 0);
    chk(d == shadow[62], "R3", "hit data", d, shadow[62]);
    chk(log_n == b, "R3", "hit memory traffic", 32'(log_n - b), 0);
  endtask

  task automatic t_write_hit();
    logic [31:0] d; int cyc, b;
    do_acc(1'b1, 32'h0000_0088, 32'hCAFE_0001, d, cyc, b);
    chk(cyc == 0 && log_n == b, "R4", "store hit cost", 32'(cyc + log_n - b), 0);
    do_acc(1'b0, 32'h0000_0088, '0, d, cyc, b);
    chk(d == 32'hCAFE_0001, "R4", "store readback", d, 32'hCAFE_0001);
    chk(bmem[34] == pattern(34), "R4", "memory untouched", bmem[34], pattern(34));
  endtask

  // set 4, word 5
  task automatic t_write_miss();
    logic [31:0] d; int cyc, b;
    do_acc(1'b1, 32'h0000_0214, 32'hBEEF_0005, d, cyc, b);
    exp_miss++;
    chk(log_n - b == 32, "R7", "allocate refill beats", 32'(log_n - b), 32);
    chk_burst(b, 1'b0, 32'h0000_0200, "R7");
    do_acc(1'b0, 32'h0000_0214, '0, d, cyc, b);
    chk(d == 32'hBEEF_0005 && cyc == 0, "R7", "merged word", d, 32'hBEEF_0005);
    do_acc(1'b0, 32'h0000_0218, '0, d, cyc, b);
    chk(d == pattern(134), "R7", "neighbour word", d, pattern(134));
  endtask

  // tag 1 set 1 evicts dirty tag 0 set 1
  task automatic t_dirty_evict();
    logic [31:0] d; int cyc, b;
    do_acc(1'b0, 32'h0000_0884, '0, d, cyc, b);
    exp_miss++; exp_wb++;
    chk(log_n - b == 64, "R6", "evict plus refill beats", 32'(log_n - b), 64);
    chk_burst(b, 1'b1, 32'h0000_0080, "R6");
    chk_burst(b + 32, 1'b0, 32'h0000_0880, "R6");
    chk(bmem[34] == 32'hCAFE_0001, "R6", "written back value", bmem[34], 32'hCAFE_0001);
    chk(d == shadow[545], "R6", "new line data", d, shadow[545]);
  endtask

  // old line comes back clean from memory; new occupant was clean
  task automatic t_refetch();
    logic [31:0] d; int cyc, b;
    do_acc(1'b0, 32'h0000_0088, '0, d, cyc, b);
    exp_miss++;
    chk(log_n - b == 32 && !log_wr[b], "R6", "clean victim no write-back", 32'(log_n - b), 32);
    chk(d == 32'hCAFE_0001, "R6", "refetched store", d, 32'hCAFE_0001);
  endtask

  // read-only sweep over fresh sets and a repeat
  task automatic t_read_only();
    logic [31:0] d; int cyc, b;
    int wb0 = exp_wb;
    for (int s = 8; s < 11; s++) begin
      do_acc(1'b0, 32'(s * 128 + 12), '0, d, cyc, b);
      exp_miss++;
      chk(d == shadow[s*32+3], "R3", "sweep data", d, shadow[s*32+3]);
      do_acc(1'b0, 32'(s * 128 + 12), '0, d, cyc, b);
      chk(cyc == 0, "R3", "sweep rehit", 32'(cyc), 0);
    end
    chk(cnt_wb == 32'(wb0), "R10", "read-only write-backs", cnt_wb, 32'(wb0));
  endtask

  initial begin
    for (int i = 0; i < MEM_WORDS; i++) shadow[i] = pattern(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_miss_clean();
    t_read_hit();
    t_write_hit();
    chk_counters("after hits");
    t_write_miss();
    t_dirty_evict();
    t_refetch();
    chk_counters("after evictions");
    t_read_only();
    chk_counters("final");
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule